// File: doc/BRIEF.md
# Posted Write Queue with Lone I/O Stall

This block sits between an internal write requester and an external bus master. It holds up to four pending write transfers. Each transfer carries a 32-bit address, 32-bit data, four byte enables and a flag that marks it as memory space or I/O space. A memory write is acknowledged as soon as it is stored, so the requester can go on with its work while the bus side empties the queue in arrival order. The bus side uses a valid/ready handshake.

I/O writes are treated in one of two ways. The requester marks an I/O write that has more I/O writes right behind it in the same run, and such a write is posted like a memory write. A lone I/O write has no such mark. The block holds it until the queue is empty, then puts it on the bus, and keeps the requester stalled until the bus side signals that the write has completed. A `drained` output tells a fence or read path that no posted write is still outstanding.

Top module: `posted_wbuf`

## Requirements
- R1: After a synchronous active-low reset, the queue is empty. `bus_valid` is 0, `drained` is 1, and `req_ready` is 1 for a memory write.
- R2: A posted write (`req_io`=0, or `req_io`=1 with `req_io_more`=1) is accepted in the cycle it is presented while the queue is not full. It appears on the bus outputs with identical address, data, byte enables and I/O flag no later than the next cycle once it is at the head.
- R3: Entries leave in arrival order, one per cycle in which `bus_valid` and `bus_ready` are both 1. While `bus_valid` is 1 and `bus_ready` is 0, the bus outputs hold steady.
- R4: With four entries held, `req_ready` is 0 for a posted write, even in a cycle where the head is leaving. A write offered afterwards is accepted once a slot is free.
- R5: A lone I/O write (`req_io`=1, `req_io_more`=0) gets `req_ready`=0 and is not queued while any entry is pending.
- R6: Once the queue is empty, a lone I/O write is queued and shows on the bus the next cycle with `bus_io`=1. `req_ready` stays 0 until `bus_done` is sampled high after that entry has left. `req_ready` is 1 in the following cycle, and the write is not queued a second time.
- R7: An I/O write with `req_io_more`=1 is posted behind pending entries without waiting for the queue to empty.
- R8: `drained` is 1 exactly when no entry is pending and no lone I/O write is waiting for completion.
- R9: `bus_done` has no effect on `drained` or `req_ready` while no lone I/O write is waiting for completion.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Requester offers a write |
| req_ready | output | 1 | Write accepted this cycle |
| req_addr | input | 32 | Write address |
| req_data | input | 32 | Write data |
| req_be | input | 4 | Byte enables |
| req_io | input | 1 | 1 = I/O space, 0 = memory space |
| req_io_more | input | 1 | With req_io: further I/O writes follow in this run |
| bus_valid | output | 1 | Head entry presented to the bus master |
| bus_ready | input | 1 | Bus master takes the head entry |
| bus_addr | output | 32 | Head entry address |
| bus_data | output | 32 | Head entry data |
| bus_be | output | 4 | Head entry byte enables |
| bus_io | output | 1 | Head entry space flag |
| bus_done | input | 1 | Completion of the issued lone I/O write |
| drained | output | 1 | No write outstanding |

## Verification
The assertions assume that the requester keeps `req_valid` and every request field steady from the cycle it raises `req_valid` until the cycle `req_ready` is 1. They also assume that the bus master raises `bus_done` for a lone I/O write only in a cycle after that entry has left the queue. Each bench task drives inputs at the falling edge and changes a request only after a handshake has completed. The bench pulses `bus_done` several cycles after the lone I/O entry has been taken, so the stimulus stays inside these assumptions.

// File: rtl/posted_wbuf_pkg.sv
// Package: shared widths, entry record and controller states for the
// posted write queue. Assumes a byte-addressed bus with byte enables.
package posted_wbuf_pkg;
    localparam int ADDR_W = 32;
    localparam int DATA_W = 32;
    localparam int BE_W   = DATA_W / 8;

    // One pending write transfer.
    typedef struct packed {
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] data;
        logic [BE_W-1:0]   be;
        logic              io;
    } wr_entry_t;

    // Controller states: posting, waiting on a lone I/O, acknowledging it.
    typedef enum logic [1:0] {
        ST_POST = 2'd0,
        ST_WAIT = 2'd1,
        ST_ACK  = 2'd2
    } wbuf_state_e;
endpackage

// File: rtl/posted_wbuf_fifo.sv
// Module: in-order storage for pending writes.
// Holds DEPTH entries in a circular array. A push when full and a pop when
// empty are ignored. Reset clears the pointers and the count, which drops
// every held entry. The array itself is not reset.
module posted_wbuf_fifo
    import posted_wbuf_pkg::*;
#(
    parameter int DEPTH = 4
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   push,
    input  wr_entry_t              push_entry,
    input  logic                   pop,
    output wr_entry_t              head_entry,
    output logic                   full,
    output logic                   empty,
    output logic [$clog2(DEPTH):0] count
);
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CNT_W = $clog2(DEPTH) + 1;
    localparam logic [PTR_W-1:0] LAST = PTR_W'(DEPTH - 1);
    localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(DEPTH);

    wr_entry_t        slots [DEPTH];
    logic [PTR_W-1:0] wr_ptr;
    logic [PTR_W-1:0] rd_ptr;
    logic             do_push;
    logic             do_pop;

    assign full    = (count == FULL_CNT);
    assign empty   = (count == '0);
    assign do_push = push && !full;
    assign do_pop  = pop && !empty;
    assign head_entry = slots[rd_ptr];

    // Store the incoming entry at the write pointer.
    always_ff @(posedge clk) begin
        if (do_push) begin
            slots[wr_ptr] <= push_entry;
        end
    end

    // Advance the pointers and track the fill level.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (do_push) begin
                wr_ptr <= (wr_ptr == LAST) ? '0 : wr_ptr + 1'b1;
            end
            if (do_pop) begin
                rd_ptr <= (rd_ptr == LAST) ? '0 : rd_ptr + 1'b1;
            end
            if (do_push && !do_pop) begin
                count <= count + 1'b1;
            end else if (do_pop && !do_push) begin
                count <= count - 1'b1;
            end
        end
    end
endmodule

// File: rtl/posted_wbuf_ctrl.sv
// Module: admission control for the write queue.
// Posts memory writes and I/O writes that are marked as part of a run.
// Holds a lone I/O write until the queue is empty, queues it, and then
// withholds the requester handshake until the bus signals completion.
// Assumes the requester holds its request steady until it is accepted.
module posted_wbuf_ctrl
    import posted_wbuf_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic req_valid,
    input  logic req_io,
    input  logic req_io_more,
    input  logic full,
    input  logic empty,
    input  logic bus_done,
    output logic req_ready,
    output logic push,
    output logic drained
);
    wbuf_state_e state;
    wbuf_state_e state_nxt;
    logic        lone_io;

    assign lone_io = req_io && !req_io_more;
    assign drained = empty && (state == ST_POST);

    // Decide acceptance, enqueue and the next state.
    always_comb begin
        req_ready = 1'b0;
        push      = 1'b0;
        state_nxt = state;
        unique case (state)
            ST_POST: begin
                if (lone_io) begin
                    push = req_valid && empty;
                    if (push) begin
                        state_nxt = ST_WAIT;
                    end
                end else begin
                    req_ready = !full;
                    push      = req_valid && !full;
                end
            end
            ST_WAIT: begin
                if (bus_done && empty) begin
                    state_nxt = ST_ACK;
                end
            end
            ST_ACK: begin
                req_ready = 1'b1;
                state_nxt = ST_POST;
            end
            default: state_nxt = ST_POST;
        endcase
    end

    // Register the controller state.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_POST;
        end else begin
            state <= state_nxt;
        end
    end
endmodule

// File: rtl/posted_wbuf.sv
// Module: posted write queue, the top level.
// Joins the admission controller to the in-order storage and presents the
// head entry to the bus master through a valid/ready handshake.
// Assumes that bus_done for a lone I/O write arrives after its entry has left.
module posted_wbuf
    import posted_wbuf_pkg::*;
#(
    parameter int DEPTH = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_data,
    input  logic [BE_W-1:0]   req_be,
    input  logic              req_io,
    input  logic              req_io_more,
    output logic              bus_valid,
    input  logic              bus_ready,
    output logic [ADDR_W-1:0] bus_addr,
    output logic [DATA_W-1:0] bus_data,
    output logic [BE_W-1:0]   bus_be,
    output logic              bus_io,
    input  logic              bus_done,
    output logic              drained
);
    localparam int CNT_W = $clog2(DEPTH) + 1;

    wr_entry_t        in_entry;
    wr_entry_t        head;
    logic             push;
    logic             full;
    logic             empty;
    logic [CNT_W-1:0] fill_count;

    assign in_entry = '{addr: req_addr, data: req_data, be: req_be, io: req_io};

    posted_wbuf_ctrl ctrl_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .req_valid  (req_valid),
        .req_io     (req_io),
        .req_io_more(req_io_more),
        .full       (full),
        .empty      (empty),
        .bus_done   (bus_done),
        .req_ready  (req_ready),
        .push       (push),
        .drained    (drained)
    );

    posted_wbuf_fifo #(.DEPTH(DEPTH)) fifo_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .push      (push),
        .push_entry(in_entry),
        .pop       (bus_valid && bus_ready),
        .head_entry(head),
        .full      (full),
        .empty     (empty),
        .count     (fill_count)
    );

    assign bus_valid = !empty;
    assign bus_addr  = head.addr;
    assign bus_data  = head.data;
    assign bus_be    = head.be;
    assign bus_io    = head.io;
endmodule

// File: rtl/posted_wbuf_chk.sv
// Module: protocol checker bound to the posted write queue.
// Assumes that requests are held until accepted and that bus_done follows
// the departure of the lone I/O entry.
module posted_wbuf_chk
    import posted_wbuf_pkg::*;
#(
    parameter int DEPTH = 4
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic                   req_valid,
    input logic                   req_ready,
    input logic                   req_io,
    input logic                   req_io_more,
    input logic                   bus_valid,
    input logic                   bus_ready,
    input logic [ADDR_W-1:0]      bus_addr,
    input logic [DATA_W-1:0]      bus_data,
    input logic [BE_W-1:0]        bus_be,
    input logic                   bus_io,
    input logic                   bus_done,
    input logic                   drained,
    input logic [$clog2(DEPTH):0] fill_count
);
    AST_BUS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        bus_valid && !bus_ready |=> bus_valid && $stable(bus_addr) && $stable(bus_data)
            && $stable(bus_be) && $stable(bus_io)); // R3

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        fill_count <= ($clog2(DEPTH) + 1)'(DEPTH)); // R4

    AST_POSTED_SHOWS: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && req_ready && !(req_io && !req_io_more) |=> bus_valid); // R2

    AST_LONE_IO_BLOCKED: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && req_io && !req_io_more && bus_valid |-> !req_ready); // R5

    AST_LONE_ACK_AFTER_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && req_io && !req_io_more && req_ready |-> $past(bus_done)); // R6

    AST_DRAINED_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
        drained |-> !bus_valid); // R8
endmodule

bind posted_wbuf posted_wbuf_chk #(.DEPTH(DEPTH)) chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_valid  (req_valid),
    .req_ready  (req_ready),
    .req_io     (req_io),
    .req_io_more(req_io_more),
    .bus_valid  (bus_valid),
    .bus_ready  (bus_ready),
    .bus_addr   (bus_addr),
    .bus_data   (bus_data),
    .bus_be     (bus_be),
    .bus_io     (bus_io),
    .bus_done   (bus_done),
    .drained    (drained),
    .fill_count (fill_count)
);

// File: tb/posted_wbuf_tb_top.sv
// Directed bench for the posted write queue: one task per scenario.
// Inputs change on the falling edge and outputs are sampled 1 ns later.
module posted_wbuf_tb_top;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [31:0] req_addr = '0;
    logic [31:0] req_data = '0;
    logic [3:0]  req_be = '0;
    logic        req_io = 1'b0;
    logic        req_io_more = 1'b0;
    logic        bus_valid;
    logic        bus_ready = 1'b0;
    logic [31:0] bus_addr;
    logic [31:0] bus_data;
    logic [3:0]  bus_be;
    logic        bus_io;
    logic        bus_done = 1'b0;
    logic        drained;

    int n_chk = 0;
    int n_bad = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    posted_wbuf dut_i (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_addr(req_addr), .req_data(req_data), .req_be(req_be), .req_io(req_io),
        .req_io_more(req_io_more), .bus_valid(bus_valid), .bus_ready(bus_ready),
        .bus_addr(bus_addr), .bus_data(bus_data), .bus_be(bus_be), .bus_io(bus_io),
        .bus_done(bus_done), .drained(drained)
    );

    // Compare one value and report a mismatch.
    task automatic chk(input string req, input string what,
                       input logic [127:0] act, input logic [127:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // Advance to the next falling edge and let outputs settle.
    task automatic step();
        @(negedge clk);
    endtask

    // Present a request at the next falling edge and check req_ready.
    task automatic offer(input string req, input logic [31:0] a, input logic [31:0] d,
                         input logic [3:0] be, input logic io, input logic more,
                         input logic exp_ready);
        step();
        req_valid = 1'b1; req_addr = a; req_data = d; req_be = be;
        req_io = io; req_io_more = more;
        #1 chk(req, "req_ready on offer", 128'(req_ready), 128'(exp_ready));
    endtask

    // Withdraw the request at the next falling edge.
    task automatic idle();
        step();
        req_valid = 1'b0; req_io = 1'b0; req_io_more = 1'b0;
    endtask

    // Take the head entry and compare every field.
    task automatic take(input string req, input logic [31:0] a, input logic [31:0] d,
                        input logic [3:0] be, input logic io);
        step();
        bus_ready = 1'b1;
        #1;
        chk(req, "bus_valid", 128'(bus_valid), 128'(1));
        chk(req, "head fields", {bus_addr, bus_data, bus_be, bus_io}, {a, d, be, io});
        step();
        bus_ready = 1'b0;
    endtask

    // Reset state of the outputs.
    task automatic t_reset();
        rst_n = 1'b0;
        repeat (3) step();
        rst_n = 1'b1;
        #1;
        chk("R1", "bus_valid after reset", 128'(bus_valid), 128'(0));
        chk("R1", "drained after reset", 128'(drained), 128'(1));
        chk("R1", "req_ready after reset", 128'(req_ready), 128'(1));
    endtask

    // One memory write is posted and reaches the bus unchanged.
    task automatic t_single_post();
        offer("R2", 32'h1000_0010, 32'hDEAD_BEEF, 4'b1111, 1'b0, 1'b0, 1'b1);
        idle();
        #1;
        chk("R2", "bus_valid next cycle", 128'(bus_valid), 128'(1));
        chk("R8", "drained with entry", 128'(drained), 128'(0));
        take("R2", 32'h1000_0010, 32'hDEAD_BEEF, 4'b1111, 1'b0);
        #1 chk("R8", "drained after take", 128'(drained), 128'(1));
    endtask

    // Fill all four slots, stall, then drain in arrival order.
    task automatic t_fill_order();
        for (int i = 0; i < 4; i++) begin
            offer("R4", 32'h2000_0000 + 32'(i * 4), 32'hA0 + 32'(i), 4'(i + 1), 1'b0, 1'b0, 1'b1);
        end
        offer("R4", 32'h2000_0010, 32'hA4, 4'b0101, 1'b0, 1'b0, 1'b0);
        chk("R3", "head held while stalled", 128'(bus_addr), 128'(32'h2000_0000));
        step();
        bus_ready = 1'b1;
        #1 chk("R4", "no accept while full during pop", 128'(req_ready), 128'(0));
        step();
        bus_ready = 1'b0;
        #1 chk("R4", "accept after slot frees", 128'(req_ready), 128'(1));
        idle();
        for (int i = 1; i < 5; i++) begin
            take("R3", 32'h2000_0000 + 32'(i * 4), 32'hA0 + 32'(i),
                 (i == 4) ? 4'b0101 : 4'(i + 1), 1'b0);
        end
        #1 chk("R3", "empty after drain", 128'(bus_valid), 128'(0));
    endtask

    // I/O writes marked as a run are posted behind a pending entry.
    task automatic t_io_run();
        offer("R7", 32'h3000_0000, 32'h11, 4'b0001, 1'b0, 1'b0, 1'b1);
        offer("R7", 32'h0000_0080, 32'h22, 4'b0011, 1'b1, 1'b1, 1'b1);
        offer("R7", 32'h0000_0084, 32'h33, 4'b1100, 1'b1, 1'b1, 1'b1);
        idle();
        take("R7", 32'h3000_0000, 32'h11, 4'b0001, 1'b0);
        take("R7", 32'h0000_0080, 32'h22, 4'b0011, 1'b1);
        take("R7", 32'h0000_0084, 32'h33, 4'b1100, 1'b1);
    endtask

    // A lone I/O write waits for the queue to empty, then for bus_done.
    task automatic t_lone_io();
        offer("R5", 32'h4000_0000, 32'h55, 4'b1111, 1'b0, 1'b0, 1'b1);
        offer("R5", 32'h0000_0060, 32'h66, 4'b0001, 1'b1, 1'b0, 1'b0);
        step();
        #1;
        chk("R5", "lone held", 128'(req_ready), 128'(0));
        chk("R5", "only memory entry queued", 128'(bus_addr), 128'(32'h4000_0000));
        take("R5", 32'h4000_0000, 32'h55, 4'b1111, 1'b0);
        #1 chk("R6", "ready low at issue", 128'(req_ready), 128'(0));
        step();
        #1;
        chk("R6", "lone io on bus", {bus_valid, bus_io, bus_addr}, {1'b1, 1'b1, 32'h0000_0060});
        chk("R8", "not drained while waiting", 128'(drained), 128'(0));
        chk("R6", "ready low before take", 128'(req_ready), 128'(0));
        take("R6", 32'h0000_0060, 32'h66, 4'b0001, 1'b1);
        repeat (2) begin
            step();
            #1 chk("R6", "ready low before done", 128'(req_ready), 128'(0));
        end
        chk("R8", "not drained before done", 128'(drained), 128'(0));
        step();
        bus_done = 1'b1;
        #1 chk("R6", "ready low in done cycle", 128'(req_ready), 128'(0));
        step();
        bus_done = 1'b0;
        #1 chk("R6", "ready high after done", 128'(req_ready), 128'(1));
        idle();
        #1;
        chk("R6", "no second enqueue", 128'(bus_valid), 128'(0));
        chk("R8", "drained after completion", 128'(drained), 128'(1));
    endtask

    // bus_done with nothing waiting changes neither drained nor req_ready.
    task automatic t_stray_done();
        step();
        bus_done = 1'b1;
        step();
        bus_done = 1'b0;
        #1 chk("R9", "drained after stray done", 128'(drained), 128'(1));
        offer("R9", 32'h5000_0000, 32'h77, 4'b1000, 1'b0, 1'b0, 1'b1);
        idle();
        take("R9", 32'h5000_0000, 32'h77, 4'b1000, 1'b0);
    endtask

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        #(CLK_PERIOD * 200000);
        n_bad++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    // Run every scenario in turn.
    initial begin
        t_reset();
        t_single_post();
        t_fill_order();
        t_io_run();
        t_lone_io();
        t_stray_done();
        repeat (2) step();
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end
endmodule